// File: doc/BRIEF.md
# Boot Record Download Sequencer

This block is a host-side master that loads the memory of a target processor through that processor's memory-access port. It takes a stream of 16-bit boot-record words on a valid/ready handshake and turns each record into bus cycles on the port. Each segment starts with a word count. A control word follows with the memory-type bit and the start address, then an overlay word, then the payload words. The block drives the control word and the overlay word in two separate address-latch cycles. It then writes each payload word in its own write cycle. The port's own address auto-increment places the payload words in consecutive locations.

Before every bus cycle the block waits until the target's acknowledge shows the port is ready. The strobes of each cycle then stay active for a fixed number of clocks. A program opcode takes two payload words: the upper 16 bits come first, then the low 8 bits right-justified. The block passes these through as plain words. A boot image should load program memory from address 0x0001 upward and write address 0x0000, which holds the restart vector, in its final segment. Loading ends when the word 0xFFFF arrives in the count position. If the stream closes before that marker arrives, or an overlay word is malformed, the block raises an error flag and stops.

Top module: `boot_dl_seq`

## Requirements
- R1: After reset `rec_ready` is 1 and `port_sel`, `port_ale`, `port_wr`, `load_done` and `load_err` are all 0.
- R2: A word of 0xFFFF accepted where a count is expected raises `load_done` and starts no bus cycle.
- R3: The control word that follows a count is driven on `port_dq` in a latch cycle: `port_sel` and `port_ale` high, `port_wr` low. `port_dq` stays stable while `port_sel` is high.
- R4: The overlay word that follows the control word gets a separate latch cycle of its own. If bit 15 of the overlay word is 0, `load_err` rises and no cycle is made for that word.
- R5: A count of N is followed by N payload words. Each payload word gets one write cycle (`port_sel` and `port_wr` high, `port_ale` low), in stream order. The word after the last payload word is read as a new count. When N is 0, the next count follows the overlay word directly.
- R6: In every cycle the strobes stay high for exactly STROBE_CLKS clocks. All strobes are low between two cycles.
- R7: A bus cycle does not begin until `port_ack` (1 = port ready) has been sampled high. While `port_ack` stays low, the strobes stay low.
- R8: When `rec_last` comes with any word other than the end marker in the count position, `load_err` rises and that word gets no bus cycle.
- R9: `load_done` and `load_err` are never both high. Each one holds until reset, and `rec_ready` stays 0 while either is high.
- R10: From the acceptance of a word that needs a bus cycle until that cycle ends, `rec_ready` is 0.
- R11: A payload word of 0xFFFF is written as data and does not end the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record word valid |
| rec_word | input | 16 | Record word |
| rec_last | input | 1 | Marks the final word of the stream |
| rec_ready | output | 1 | Block accepts a record word |
| port_ack | input | 1 | Target port ready (1) or busy (0) |
| port_dq | output | 16 | Port address/data bus |
| port_sel | output | 1 | Port select strobe, active high |
| port_ale | output | 1 | Address-latch strobe, active high |
| port_wr | output | 1 | Write strobe, active high |
| load_done | output | 1 | End marker reached |
| load_err | output | 1 | Stream closed early or bad overlay word |

## Verification
The assertions treat `port_ack` as a free input that may change on any clock. They do not require the record stream to be well formed. Their only requirement is that reset is held across at least one rising edge before checking starts. The stimulus changes inputs just after a rising edge and samples outputs on the falling edge. It keeps `rec_word` and `rec_last` steady while `rec_valid` waits for `rec_ready`. It holds `port_ack` low across a pending cycle to show the wait.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] END_MARK = 16'hFFFF;

  typedef enum logic [1:0] {K_COUNT, K_CTRL, K_OVL, K_DATA} word_kind_e;

  function automatic logic is_end_mark(input logic [WORD_W-1:0] w);
    return w == END_MARK;
  endfunction

  function automatic logic overlay_ok(input logic [WORD_W-1:0] w);
    return w[WORD_W-1];
  endfunction

  // Kind of the next expected word once a bus cycle for kind k has finished
  function automatic word_kind_e kind_after(input word_kind_e k, input logic [WORD_W-1:0] left);
    case (k)
      K_CTRL:  return K_OVL;
      K_OVL:   return (left == '0) ? K_COUNT : K_DATA;
      K_DATA:  return (left == WORD_W'(1)) ? K_COUNT : K_DATA;
      default: return K_CTRL;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] left_after(input word_kind_e k, input logic [WORD_W-1:0] left);
    return (k == K_DATA) ? left - WORD_W'(1) : left;
  endfunction
endpackage

// File: rtl/bsq_strobe.sv
module bsq_strobe #(
  parameter int STROBE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_latch,
  input  logic ack,
  output logic busy,
  output logic cyc_done,
  output logic sel,
  output logic ale,
  output logic wr
);
  localparam int TW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} st_e;
  st_e st_q;
  logic [TW-1:0] tmr_q;
  logic latch_q;
  logic active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      tmr_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q    <= S_WAIT;
          latch_q <= is_latch;
        end
        S_WAIT: if (ack) begin
          st_q  <= S_HOLD;
          tmr_q <= TW'(STROBE_CLKS - 1);
        end
        S_HOLD: begin
          if (tmr_q == '0) st_q <= S_IDLE;
          else tmr_q <= tmr_q - TW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign active   = (st_q == S_HOLD);
  assign sel      = active;
  assign ale      = active & latch_q;
  assign wr       = active & ~latch_q;
  assign busy     = (st_q != S_IDLE);
  assign cyc_done = active && (tmr_q == '0);

  // R7: a strobe only rises after ready was seen on the edge before
  p_ack_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(ack));
  // R6: strobe drops right after the cycle completes
  p_gap_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !sel);
endmodule

// File: rtl/bsq_parser.sv
module bsq_parser
  import bsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_word,
  input  logic              s_last,
  output logic              s_ready,
  output logic              start,
  output logic              is_latch,
  input  logic              cyc_done,
  input  logic              busy,
  output logic [WORD_W-1:0] word_q,
  output logic              done,
  output logic              err
);
  typedef enum logic [1:0] {P_FETCH, P_BUS, P_DONE, P_ERR} pst_e;
  pst_e st_q;
  word_kind_e kind_q;
  logic [WORD_W-1:0] left_q;
  logic fire, bad, ending;

  assign s_ready  = (st_q == P_FETCH) && !busy;
  assign fire     = s_valid && s_ready;
  assign ending   = fire && (kind_q == K_COUNT) && is_end_mark(s_word);
  assign bad      = fire && ((s_last && !((kind_q == K_COUNT) && is_end_mark(s_word)))
                          || ((kind_q == K_OVL) && !overlay_ok(s_word)));
  assign start    = fire && !bad && (kind_q != K_COUNT);
  assign is_latch = (kind_q == K_CTRL) || (kind_q == K_OVL);
  assign done     = (st_q == P_DONE);
  assign err      = (st_q == P_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= P_FETCH;
      kind_q <= K_COUNT;
      left_q <= '0;
      word_q <= '0;
    end else begin
      case (st_q)
        P_FETCH: begin
          if (bad) st_q <= P_ERR;
          else if (ending) st_q <= P_DONE;
          else if (fire) begin
            if (kind_q == K_COUNT) begin
              left_q <= s_word;
              kind_q <= K_CTRL;
            end else begin
              word_q <= s_word;
              st_q   <= P_BUS;
            end
          end
        end
        P_BUS: if (cyc_done) begin
          kind_q <= kind_after(kind_q, left_q);
          left_q <= left_after(kind_q, left_q);
          st_q   <= P_FETCH;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  // R10: no word is taken while the strobe engine has a cycle pending
  p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy);
  // R9: final flags are exclusive and hold
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !s_ready);
endmodule

// File: rtl/boot_dl_seq.sv
module boot_dl_seq #(
  parameter int STROBE_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rec_valid,
  input  logic [15:0] rec_word,
  input  logic        rec_last,
  output logic        rec_ready,
  input  logic        port_ack,
  output logic [15:0] port_dq,
  output logic        port_sel,
  output logic        port_ale,
  output logic        port_wr,
  output logic        load_done,
  output logic        load_err
);
  logic start, is_latch, cyc_done, busy;

  bsq_parser u_parser (
    .clk(clk), .rst_n(rst_n),
    .s_valid(rec_valid), .s_word(rec_word), .s_last(rec_last), .s_ready(rec_ready),
    .start(start), .is_latch(is_latch), .cyc_done(cyc_done), .busy(busy),
    .word_q(port_dq), .done(load_done), .err(load_err)
  );

  bsq_strobe #(.STROBE_CLKS(STROBE_CLKS)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .start(start), .is_latch(is_latch), .ack(port_ack),
    .busy(busy), .cyc_done(cyc_done),
    .sel(port_sel), .ale(port_ale), .wr(port_wr)
  );

  // R3: bus data held for the whole strobe
  p_dq_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel && $past(port_sel)) |-> $stable(port_dq));
  // R3/R5: exactly one kind of strobe while selected, none otherwise
  p_strobe_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel ? (port_ale != port_wr) : !(port_ale || port_wr));
  // R10: stream stalled during a strobe
  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel |-> !rec_ready);
endmodule

// File: tb/test_boot_dl_seq.sv
module test_boot_dl_seq;
  localparam int STROBE = 3;

  logic clk = 0, rst_n = 0;
  logic rec_valid = 0, rec_last = 0, port_ack = 1;
  logic [15:0] rec_word = '0;
  logic rec_ready, port_sel, port_ale, port_wr, load_done, load_err;
  logic [15:0] port_dq;

  int checks = 0, errors = 0, viol = 0;
  int mon_n = 0;
  logic [15:0] mon_data [0:15];
  logic        mon_latch[0:15];
  int          mon_len  [0:15];
  logic prev_sel = 0, prev_ack = 1;

  always #10 clk = ~clk;

  boot_dl_seq #(.STROBE_CLKS(STROBE)) i_boot_dl_seq (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_word(rec_word),
    .rec_last(rec_last), .rec_ready(rec_ready), .port_ack(port_ack),
    .port_dq(port_dq), .port_sel(port_sel), .port_ale(port_ale), .port_wr(port_wr),
    .load_done(load_done), .load_err(load_err));

  // bus monitor: logs each cycle, its kind, data and strobe length
  always @(negedge clk) begin
    if (rst_n) begin
      if (port_sel && !prev_sel) begin
        if (!prev_ack) viol++;
        if (mon_n < 16) begin
          mon_latch[mon_n] = port_ale;
          mon_data[mon_n]  = port_dq;
          mon_len[mon_n]   = 1;
        end
        mon_n++;
      end else if (port_sel && mon_n > 0 && mon_n <= 16) begin
        mon_len[mon_n-1]++;
        if (port_dq != mon_data[mon_n-1]) viol++;
      end
      if (port_sel && (port_ale == port_wr)) viol++;
      if (!port_sel && (port_ale || port_wr)) viol++;
      prev_sel = port_sel;
      prev_ack = port_ack;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; rec_valid = 0; rec_last = 0; port_ack = 1;
    repeat (3) @(posedge clk);
    mon_n = 0; viol = 0; prev_sel = 0; prev_ack = 1;
    #2 rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input logic last = 0);
    @(posedge clk); #2;
    rec_valid = 1; rec_word = w; rec_last = last;
    forever begin
      @(negedge clk);
      if (rec_ready) break;
    end
    @(posedge clk); #2;
    rec_valid = 0; rec_last = 0;
  endtask

  task automatic exp_cyc(input int i, input bit latch, input logic [15:0] d, input string tag);
    chk(mon_latch[i] == latch, {tag, " cycle kind"}, mon_latch[i], latch);
    chk(mon_data[i] == d, {tag, " cycle data"}, mon_data[i], d);
    chk(mon_len[i] == STROBE, "R6 strobe length", mon_len[i], STROBE);
  endtask

  task automatic t_reset();
    do_reset();
    chk(rec_ready == 1, "R1 ready", rec_ready, 1);
    chk({port_sel, port_ale, port_wr} == 3'b000, "R1 strobes", {port_sel, port_ale, port_wr}, 0);
    chk(load_done == 0 && load_err == 0, "R1 flags", {load_done, load_err}, 0);
  endtask

  task automatic t_basic();
    do_reset();
    send(16'd2); send(16'h4001); send(16'h8000); send(16'h1234); send(16'h0056);
    send(16'hFFFF, 1);
    repeat (3) @(negedge clk);
    chk(mon_n == 4, "R5 cycle count", mon_n, 4);
    exp_cyc(0, 1, 16'h4001, "R3");
    exp_cyc(1, 1, 16'h8000, "R4");
    exp_cyc(2, 0, 16'h1234, "R5");
    exp_cyc(3, 0, 16'h0056, "R5");
    chk(load_done == 1 && load_err == 0, "R2 done", {load_done, load_err}, 2);
    chk(rec_ready == 0, "R9 ready after done", rec_ready, 0);
    repeat (4) @(negedge clk);
    chk(load_done == 1, "R9 done holds", load_done, 1);
    chk(viol == 0, "R6 strobe shape", viol, 0);
  endtask

  task automatic t_empty_and_ffff();
    do_reset();
    send(16'd0); send(16'h0001); send(16'h8001);
    send(16'd1); send(16'h0000); send(16'h8000); send(16'hFFFF);
    repeat (3) @(negedge clk);
    chk(load_done == 0, "R11 payload FFFF not end", load_done, 0);
    send(16'hFFFF, 1);
    repeat (3) @(negedge clk);
    chk(mon_n == 5, "R5 empty segment count", mon_n, 5);
    exp_cyc(2, 1, 16'h0000, "R5 count after empty");
    exp_cyc(4, 0, 16'hFFFF, "R11");
    chk(load_done == 1, "R2 done", load_done, 1);
  endtask

  task automatic t_ack_wait();
    do_reset();
    port_ack = 0;
    send(16'd1); send(16'h0010);
    repeat (10) @(negedge clk);
    chk(mon_n == 0 && port_sel == 0, "R7 no strobe while busy", mon_n, 0);
    chk(rec_ready == 0, "R10 stalled", rec_ready, 0);
    @(posedge clk); #2 port_ack = 1;
    send(16'h8002);
    @(posedge clk); #2 port_ack = 0;
    send(16'h0BEE);
    repeat (6) @(negedge clk);
    chk(mon_n == 2, "R7 write waits", mon_n, 2);
    @(posedge clk); #2 port_ack = 1;
    send(16'hFFFF, 1);
    repeat (3) @(negedge clk);
    chk(mon_n == 3, "R7 cycles", mon_n, 3);
    exp_cyc(2, 0, 16'h0BEE, "R5");
    chk(viol == 0, "R7 ack seen first", viol, 0);
  endtask

  task automatic t_bad_overlay();
    do_reset();
    send(16'd2); send(16'h4020); send(16'h0003);
    repeat (4) @(negedge clk);
    chk(load_err == 1 && load_done == 0, "R4 bad overlay err", {load_done, load_err}, 1);
    chk(mon_n == 1, "R4 no cycle for bad overlay", mon_n, 1);
    chk(rec_ready == 0, "R9 ready after err", rec_ready, 0);
  endtask

  task automatic t_early_last();
    do_reset();
    send(16'd3); send(16'h0005, 1);
    repeat (4) @(negedge clk);
    chk(load_err == 1, "R8 early end err", load_err, 1);
    chk(mon_n == 0, "R8 no cycle", mon_n, 0);
    repeat (4) @(negedge clk);
    chk(load_err == 1 && load_done == 0, "R9 err holds", {load_done, load_err}, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_empty_and_ffff();
    t_ack_wait();
    t_bad_overlay();
    t_early_last();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule